// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Status Queue

This block turns an asynchronous serial line into a stream of characters that a host can collect at its own pace. A 16x oversampling enable, produced outside the block from a programmable divisor, paces all line sampling. Each frame is a start bit, then 5 to 8 data bits, then an optional parity bit, then one or more stop bits. Completed characters are stored with their per-character status in a first-in first-out queue, 16 entries deep by default.

The frame shape comes from live configuration inputs and can change between frames: the data length, whether parity is present and how it is computed (odd, even, fixed one or fixed zero), and a long-stop option. The long-stop option gives two stop bits for 6, 7 or 8 data bits and one and a half stop bits for 5 data bits. Sticky parity, framing and overrun flags, together with the data-ready status, drive a single interrupt request. A status-read strobe clears the sticky flags.

Top module: `srx_receiver`

## Requirements
- R1: After reset, `data_ready`, `err_parity`, `err_framing`, `err_overrun` and `irq` are all 0.
- R2: `cfg_len` selects the data length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits). Data bits arrive least-significant first, and `rd_data` bits above the configured length read 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_mode` selects the expected value: 00 gives an odd total of ones, 01 an even total, 10 a fixed 1 and 11 a fixed 0. A mismatch sets that character's `rd_perr` and the sticky `err_parity`.
- R4: A low sample at the centre of the first stop bit sets `rd_ferr` and `err_framing`. With `cfg_stop_ext` = 1, a second stop check follows: 16 oversample ticks later for 6 to 8 data bits, or 12 ticks later (inside the half stop) for 5 data bits. A low sample there is also a framing error.
- R5: A falling edge is accepted as a start bit only if the line is still low 8 oversample ticks later. Otherwise the receiver returns to idle and stores nothing.
- R6: The queue keeps up to 16 characters in arrival order. The oldest entry is shown on `rd_data`/`rd_perr`/`rd_ferr`/`rd_oerr` while `data_ready` is 1, and a one-cycle `rd_en` removes it.
- R7: A character that completes while the queue is full is discarded and sets `err_overrun`. The next character that is stored carries `rd_oerr` = 1.
- R8: `data_ready` is 1 exactly when the queue holds at least one character.
- R9: `irq` is 1 whenever `data_ready` or any sticky error flag is 1, and 0 otherwise.
- R10: A one-cycle `sts_rd` clears all three sticky error flags; an error event in the same cycle still sets its flag.
- R11: The receiver state advances only on cycles where `os_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity mode code |
| cfg_stop_ext | input | 1 | Long stop option |
| rd_en | input | 1 | Remove oldest character |
| rd_data | output | 8 | Oldest character data |
| rd_perr | output | 1 | Oldest character parity error |
| rd_ferr | output | 1 | Oldest character framing error |
| rd_oerr | output | 1 | Overrun happened before this character |
| data_ready | output | 1 | Queue not empty |
| sts_rd | input | 1 | Status read, clears sticky flags |
| err_parity | output | 1 | Sticky parity error |
| err_framing | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the rules that depend on a single clock step. The sampler moves only on oversample ticks and emits one-cycle character pulses that start from a stop state. The queue is never written past full or read while empty. The sticky flags hold until a status read and are set by an overrun. The interrupt follows data-ready. Only the bench's scenarios can show the value-level results: bit order, truncation at each data length, parity results in all four modes, the timing of the second stop check for both long-stop variants, rejection of a short start glitch, arrival order across a full queue, and the overrun marker on the first character stored after a discard.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_MARK  = 2'b10,
      PAR_SPACE = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } rx_state_e;

   typedef struct packed {
      logic              ovr;
      logic              ferr;
      logic              perr;
      logic [DATA_W-1:0] data;
   } rx_entry_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial assert (STAGES >= 0 && STAGES <= 4)
      else $error("srx_sync: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic [1:0]        cfg_par_mode,
   input  logic              cfg_stop_ext,
   output logic              chr_valid,
   output logic [DATA_W-1:0] chr_data,
   output logic              chr_perr,
   output logic              chr_ferr
);

   localparam int CW    = $clog2(OSR + 1);
   localparam int MID   = OSR / 2;
   localparam int HALF3 = (OSR * 3) / 4;

   initial assert (OSR >= 4 && (OSR % 4) == 0)
      else $error("srx_framer: OSR must be a multiple of 4, at least 4");

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [2:0]        idx;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;
   logic              perr_r;
   logic              ferr_r;
   logic              exp_par;
   logic [2:0]        last_idx;
   logic [CW-1:0]     stop2_tgt;

   assign last_idx  = 3'd4 + {1'b0, cfg_len};
   assign stop2_tgt = (cfg_len == 2'b00) ? CW'(HALF3) : CW'(OSR);

   always_comb begin
      case (par_mode_e'(cfg_par_mode))
         PAR_ODD:   exp_par = ~par_acc;
         PAR_EVEN:  exp_par = par_acc;
         PAR_MARK:  exp_par = 1'b1;
         default:   exp_par = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         perr_r    <= 1'b0;
         ferr_r    <= 1'b0;
         chr_valid <= 1'b0;
         chr_data  <= '0;
         chr_perr  <= 1'b0;
         chr_ferr  <= 1'b0;
      end else begin
         chr_valid <= 1'b0;
         if (tick) begin
            case (st)
               ST_IDLE: begin
                  if (!rx) begin
                     st  <= ST_START;
                     cnt <= CW'(1);
                  end
               end
               ST_START: begin
                  if (cnt == CW'(MID)) begin
                     if (rx) begin
                        st <= ST_IDLE;
                     end else begin
                        st      <= ST_DATA;
                        cnt     <= CW'(1);
                        idx     <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        perr_r  <= 1'b0;
                        ferr_r  <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_DATA: begin
                  if (cnt == CW'(OSR)) begin
                     shreg[idx] <= rx;
                     par_acc    <= par_acc ^ rx;
                     cnt        <= CW'(1);
                     if (idx == last_idx) st <= cfg_par_en ? ST_PAR : ST_STOP1;
                     else                 idx <= idx + 3'd1;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_PAR: begin
                  if (cnt == CW'(OSR)) begin
                     perr_r <= (rx != exp_par);
                     cnt    <= CW'(1);
                     st     <= ST_STOP1;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_STOP1: begin
                  if (cnt == CW'(OSR)) begin
                     cnt <= CW'(1);
                     if (cfg_stop_ext) begin
                        ferr_r <= !rx;
                        st     <= ST_STOP2;
                     end else begin
                        chr_valid <= 1'b1;
                        chr_data  <= shreg;
                        chr_perr  <= perr_r;
                        chr_ferr  <= !rx;
                        st        <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_STOP2: begin
                  if (cnt == stop2_tgt) begin
                     chr_valid <= 1'b1;
                     chr_data  <= shreg;
                     chr_perr  <= perr_r;
                     chr_ferr  <= ferr_r | !rx;
                     st        <= ST_IDLE;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R11: the sampler only moves on oversample ticks
   a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(st));

   // R6: a finished character is reported for exactly one cycle
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid |=> !chr_valid);

   // R4: characters are only reported after a stop-bit check
   a_r4_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chr_valid) |-> ($past(st) == ST_STOP1 || $past(st) == ST_STOP2));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("srx_fifo: DEPTH must be a power of two, at least 2");

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic [CW-1:0] count;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_en) wptr <= wptr + AW'(1);
         if (rd_en) rptr <= rptr + AW'(1);
         case ({wr_en, rd_en})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R6: no write past full unless a read frees a slot
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |-> rd_en);

   // R6: no read from an empty queue
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
   import srx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rx_in,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic [1:0] cfg_par_mode,
   input  logic       cfg_stop_ext,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       rd_perr,
   output logic       rd_ferr,
   output logic       rd_oerr,
   output logic       data_ready,
   input  logic       sts_rd,
   output logic       err_parity,
   output logic       err_framing,
   output logic       err_overrun,
   output logic       irq
);

   localparam int EW = $bits(rx_entry_t);

   logic              rx_s;
   logic              chr_valid;
   logic [DATA_W-1:0] chr_data;
   logic              chr_perr;
   logic              chr_ferr;
   logic              q_empty;
   logic              q_full;
   logic              pop;
   logic              push;
   logic              drop;
   logic              ovr_pend;
   rx_entry_t         wr_e;
   rx_entry_t         rd_e;
   logic [EW-1:0]     rd_raw;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rx_s)
   );

   srx_framer #(.OSR(OSR)) u_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (os_tick),
      .rx           (rx_s),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_mode (cfg_par_mode),
      .cfg_stop_ext (cfg_stop_ext),
      .chr_valid    (chr_valid),
      .chr_data     (chr_data),
      .chr_perr     (chr_perr),
      .chr_ferr     (chr_ferr)
   );

   assign pop  = rd_en && !q_empty;
   assign push = chr_valid && (!q_full || pop);
   assign drop = chr_valid && !push;

   assign wr_e.ovr  = ovr_pend;
   assign wr_e.ferr = chr_ferr;
   assign wr_e.perr = chr_perr;
   assign wr_e.data = chr_data;

   srx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_data (wr_e),
      .rd_en   (pop),
      .rd_data (rd_raw),
      .empty   (q_empty),
      .full    (q_full)
   );

   assign rd_e       = rx_entry_t'(rd_raw);
   assign rd_data    = rd_e.data;
   assign rd_perr    = rd_e.perr;
   assign rd_ferr    = rd_e.ferr;
   assign rd_oerr    = rd_e.ovr;
   assign data_ready = !q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_pend    <= 1'b0;
         err_parity  <= 1'b0;
         err_framing <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (drop)      ovr_pend <= 1'b1;
         else if (push) ovr_pend <= 1'b0;
         err_parity  <= (err_parity  && !sts_rd) || (chr_valid && chr_perr);
         err_framing <= (err_framing && !sts_rd) || (chr_valid && chr_ferr);
         err_overrun <= (err_overrun && !sts_rd) || drop;
      end
   end

   assign irq = data_ready || err_parity || err_framing || err_overrun;

   // R8: the queue only becomes non-empty after a finished character
   a_r8_ready_from_char: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(chr_valid));

   // R7: a discarded character raises the overrun flag
   a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> err_overrun);

   // R10: flags hold until a status read
   a_r10_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity && !sts_rd) |=> err_parity);

   a_r10_framing_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_framing && !sts_rd) |=> err_framing);

   // R10: a status read with no event clears every flag
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && !chr_valid) |=> (!err_parity && !err_framing && !err_overrun));

   // R9: interrupt covers data ready
   a_r9_irq_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> irq);

endmodule

// File: tb/srx_receiver_tb.sv
module srx_receiver_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int BIT_CLK    = 16 * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] cfg_len = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic [1:0] cfg_par_mode = 2'b00;
   logic       cfg_stop_ext = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, rd_oerr;
   logic       data_ready;
   logic       sts_rd = 1'b0;
   logic       err_parity, err_framing, err_overrun, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int tick_cnt = 0;

   logic [10:0] exp_q[$];
   logic        m_ovr_pend = 1'b0;
   logic        m_par = 1'b0, m_frm = 1'b0, m_ovr = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   srx_receiver u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .os_tick      (os_tick),
      .rx_in        (rx_in),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_mode (cfg_par_mode),
      .cfg_stop_ext (cfg_stop_ext),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .rd_perr      (rd_perr),
      .rd_ferr      (rd_ferr),
      .rd_oerr      (rd_oerr),
      .data_ready   (data_ready),
      .sts_rd       (sts_rd),
      .err_parity   (err_parity),
      .err_framing  (err_framing),
      .err_overrun  (err_overrun),
      .irq          (irq)
   );

   always @(negedge clk) begin
      tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
      os_tick  <= (tick_cnt == TICK_DIV - 1);
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R9 compared on every clock against the output flags
   always @(negedge clk) begin
      if (rst_n && !done)
         chk("R9 irq", irq, data_ready | err_parity | err_framing | err_overrun);
   end

   task automatic hold_bits(input int clocks);
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                             input logic [1:0] pm, input logic sext,
                             input logic bad_par, input logic bad_s1, input logic bad_s2);
      logic [7:0]  mask;
      logic        x, pbit, perr, ferr;
      mask = 8'hFF >> (8 - nb);
      x = ^(d & mask);
      case (pm)
         2'b00:   pbit = ~x;
         2'b01:   pbit = x;
         2'b10:   pbit = 1'b1;
         default: pbit = 1'b0;
      endcase
      @(negedge clk);
      cfg_len      = 2'(nb - 5);
      cfg_par_en   = pen;
      cfg_par_mode = pm;
      cfg_stop_ext = sext;
      rx_in = 1'b0;
      hold_bits(BIT_CLK);
      for (int i = 0; i < nb; i++) begin
         rx_in = d[i];
         hold_bits(BIT_CLK);
      end
      if (pen) begin
         rx_in = pbit ^ bad_par;
         hold_bits(BIT_CLK);
      end
      rx_in = !bad_s1;
      hold_bits(BIT_CLK);
      if (sext) begin
         rx_in = !bad_s2;
         hold_bits((nb == 5) ? BIT_CLK / 2 : BIT_CLK);
      end
      rx_in = 1'b1;
      hold_bits(2 * BIT_CLK);
      perr = pen & bad_par;
      ferr = bad_s1 | (sext & bad_s2);
      m_par |= perr;
      m_frm |= ferr;
      if (exp_q.size() < 16) begin
         exp_q.push_back({m_ovr_pend, ferr, perr, d & mask});
         m_ovr_pend = 1'b0;
      end else begin
         m_ovr_pend = 1'b1;
         m_ovr = 1'b1;
      end
   endtask

   task automatic pop_chk(input string tag);
      logic [10:0] e;
      @(negedge clk);
      chk({tag, " ready"}, data_ready, 1);
      if (exp_q.size() == 0) begin
         chk({tag, " model empty"}, 1, 0);
      end else begin
         e = exp_q.pop_front();
         chk(tag, {rd_oerr, rd_ferr, rd_perr, rd_data}, e);
      end
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic status_chk(input string tag);
      @(negedge clk);
      chk({tag, " R8 data_ready"}, data_ready, exp_q.size() != 0);
      chk({tag, " R3 err_parity"}, err_parity, m_par);
      chk({tag, " R4 err_framing"}, err_framing, m_frm);
      chk({tag, " R7 err_overrun"}, err_overrun, m_ovr);
   endtask

   task automatic clear_status();
      @(negedge clk);
      sts_rd = 1'b1;
      @(negedge clk);
      sts_rd = 1'b0;
      m_par = 0; m_frm = 0; m_ovr = 0;
      status_chk("R10 after clear");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 data_ready", data_ready, 0);
      chk("R1 flags", {err_parity, err_framing, err_overrun}, 0);
      chk("R1 irq", irq, 0);
      rst_n = 1'b1;
      hold_bits(BIT_CLK);

      // R2 eight bits, no parity, LSB first
      send_frame(8'hA5, 8, 0, 2'b00, 0, 0, 0, 0);
      status_chk("R8 one char");
      pop_chk("R2 8-bit A5");
      send_frame(8'h3C, 8, 0, 2'b00, 0, 0, 0, 0);
      pop_chk("R2 8-bit 3C");

      // R2 shorter lengths truncate the upper bits
      send_frame(8'hFF, 5, 0, 2'b00, 0, 0, 0, 0);
      send_frame(8'hEA, 6, 0, 2'b00, 0, 0, 0, 0);
      send_frame(8'hD3, 7, 0, 2'b00, 0, 0, 0, 0);
      pop_chk("R2 5-bit");
      pop_chk("R2 6-bit");
      pop_chk("R2 7-bit");
      status_chk("R8 drained");

      // R3 all four parity modes, correct parity
      for (int m = 0; m < 4; m++) begin
         send_frame(8'h47, 8, 1, 2'(m), 0, 0, 0, 0);
         pop_chk("R3 good parity");
      end
      status_chk("R3 no error");

      // R3 each mode with a bad parity bit
      for (int m = 0; m < 4; m++) begin
         send_frame(8'h29, 7, 1, 2'(m), 0, 1, 0, 0);
         status_chk("R3 bad parity");
         pop_chk("R3 bad parity entry");
         clear_status();
      end

      // R4 framing: one stop bit low
      send_frame(8'h81, 8, 0, 2'b00, 0, 0, 1, 0);
      status_chk("R4 stop1 low");
      pop_chk("R4 stop1 entry");
      clear_status();
      // R4 two stop bits, second low
      send_frame(8'h5A, 8, 1, 2'b01, 1, 0, 0, 1);
      status_chk("R4 stop2 low");
      pop_chk("R4 stop2 entry");
      clear_status();
      // R4 two stop bits, both good
      send_frame(8'h66, 6, 0, 2'b00, 1, 0, 0, 0);
      pop_chk("R4 two stops good");
      // R4 one and a half stop bits, half stop low
      send_frame(8'h13, 5, 0, 2'b00, 1, 0, 0, 1);
      status_chk("R4 half stop low");
      pop_chk("R4 half stop entry");
      clear_status();
      // R4 one and a half stop bits, good
      send_frame(8'h0E, 5, 1, 2'b00, 1, 0, 0, 0);
      pop_chk("R4 half stop good");

      // R5 short low pulse is not a start bit
      @(negedge clk);
      rx_in = 1'b0;
      hold_bits(4 * TICK_DIV);
      rx_in = 1'b1;
      hold_bits(3 * BIT_CLK);
      status_chk("R5 glitch ignored");
      send_frame(8'hC9, 8, 0, 2'b00, 0, 0, 0, 0);
      pop_chk("R5 recovered");

      // R6 / R7 fill the queue, then overrun
      for (int i = 0; i < 17; i++)
         send_frame(8'(i * 13 + 7), 8, 0, 2'b00, 0, 0, 0, 0);
      status_chk("R7 overrun");
      for (int i = 0; i < 16; i++)
         pop_chk("R6 order");
      status_chk("R6 empty");
      send_frame(8'h77, 8, 0, 2'b00, 0, 0, 0, 0);
      pop_chk("R7 marker on next char");
      clear_status();
      send_frame(8'h78, 8, 0, 2'b00, 0, 0, 0, 0);
      pop_chk("R7 marker cleared");
      status_chk("R8 final");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule